// File: doc/BRIEF.md
# Two-wire serial target bit engine

This block is the bit-level receive and transmit engine for the target side of a two-wire serial bus (I2C). It brings the clock and data lines into the system clock domain through a two-flop synchroniser and a spike filter on each line, then recognises START and STOP conditions. It assembles incoming words of eight bits, most significant bit first, and acknowledges each one by pulling the data line low during the ninth clock. The data line is driven only through an open-drain enable, so the block can pull it low but never drive it high.

A surrounding controller watches the received-byte strobe to decode addresses and commands. When a read is to follow, it arms the engine with a byte through the load port. The armed byte goes out after the next acknowledge clock, and further bytes follow for as long as the bus controller acknowledges them and new bytes are armed. A standby flag reports when no transaction is open and no internal operation (modelled by a busy input) is in progress.

Top module: `twi_phy`

## Requirements
- R1: The filtered outputs `scl_filt` and `sda_filt` reset to 1. A level change on `scl_i` or `sda_i` reaches them only after the synchronised line has held the new level for `FILT_LEN` consecutive clocks; a pulse that lasts fewer clocks never appears.
- R2: A falling `sda_filt` while `scl_filt` is high is a START. It opens a transaction from any state, drops any partial byte and restarts the bit count, so a START in mid-byte acts as a repeated START.
- R3: A rising `sda_filt` while `scl_filt` is high is a STOP. After it, SCL clocks cause no `rx_valid` and no drive until the next START.
- R4: Data bits are sampled on each rising edge of `scl_filt`, MSB first. On the falling edge of the eighth clock, the assembled byte appears on `rx_byte` and `rx_valid` pulses for exactly one cycle, with the data line released.
- R5: During the ninth clock of every received byte, `sda_oe` is 1 (line pulled low). It is released after that clock unless a transmit byte follows.
- R6: `sda_oe` changes only after `scl_filt` has been low for at least `HOLD_CLKS` clocks, and it never rises while `scl_filt` is high.
- R7: A byte presented on `tx_byte` with a one-cycle `tx_load` after the latest START arms the engine. On the next acknowledge-clock fall, the armed byte is shifted out MSB first, with `sda_oe` = 1 for a 0 bit and 0 for a 1 bit, and the data line is released for the ninth clock.
- R8: A low `sda_filt` on the ninth clock after a sent byte is an ACK: if another byte is armed, it is sent next. A high level (NACK), or an ACK with nothing armed, ends the drive: `sda_oe` stays 0 until the next START, even if a byte is armed meanwhile.
- R9: `standby` is 1 out of reset, falls the cycle after a START, and returns to 1 after a STOP.
- R10: While `busy_i` is 1, `standby` is 0. After a STOP, `standby` returns to 1 only once `busy_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| busy_i | input | 1 | Internal operation in progress; blocks standby |
| tx_load | input | 1 | One-cycle strobe arming `tx_byte` for transmission |
| tx_byte | input | 8 | Byte to transmit |
| scl_filt | output | 1 | Synchronised, spike-filtered clock line |
| sda_filt | output | 1 | Synchronised, spike-filtered data line |
| sda_oe | output | 1 | Open-drain enable: 1 pulls the data line low |
| rx_valid | output | 1 | One-cycle strobe: `rx_byte` holds a new word |
| rx_byte | output | 8 | Last received word |
| standby | output | 1 | No open transaction and no busy operation |

## Verification
The hardest situation to reach is the end of a read sequence. The controller's NACK must stop the engine even when a further byte has already been armed, and a read byte must begin only after a received byte's acknowledge. The bench reaches it through a full written address byte with an armed byte, an acknowledged read, a second read answered with NACK and a re-arm, then nine more clocks during which the pin must stay released. Repeated START in mid-byte and STOP in mid-byte are reached by cutting a bit stream after a few clocks. The spike filter is swept over pulse widths on both lines on either side of the threshold.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_RX,
        ENG_RX_ACK,
        ENG_TX,
        ENG_TX_ACK
    } eng_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    localparam int BYTE_BITS = 8;

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic filt
);
    localparam int CW = twi_pkg::cnt_width(FILT_LEN);

    logic          sync0, sync1;
    logic          level_q;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync0   <= 1'b1;
            sync1   <= 1'b1;
            level_q <= 1'b1;
            run_cnt <= '0;
        end else begin
            sync0 <= raw;
            sync1 <= sync0;
            if (sync1 == level_q) begin
                run_cnt <= '0;
            end else if (run_cnt == CW'(FILT_LEN - 1)) begin
                level_q <= sync1;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign filt = level_q;

endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_f,
    input  logic              sda_f,
    output twi_pkg::bus_evt_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev.start = scl_f & scl_q & sda_q & ~sda_f;
        ev.stop  = scl_f & scl_q & ~sda_q & sda_f;
        ev.rise  = scl_f & ~scl_q;
        ev.fall  = ~scl_f & scl_q;
    end

endmodule

// File: rtl/twi_bit_engine.sv
module twi_bit_engine #(
    parameter int HOLD_CLKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  twi_pkg::bus_evt_t ev,
    input  logic              sda_f,
    input  logic              tx_load,
    input  logic [7:0]        tx_byte,
    output logic              sda_oe,
    output logic              rx_valid,
    output logic [7:0]        rx_byte
);
    import twi_pkg::*;

    localparam int HW = cnt_width(HOLD_CLKS);
    localparam int BW = cnt_width(BYTE_BITS);

    eng_state_e    state;
    logic [BW-1:0] bit_cnt;
    logic [7:0]    rx_sh;
    logic [7:0]    rx_hold;
    logic [7:0]    tx_buf;
    logic [7:0]    tx_sh;
    logic          armed;
    logic          ctl_ack;
    logic          drive_next;
    logic          hold_pend;
    logic [HW-1:0] hold_cnt;
    logic          oe_q;
    logic          rxv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ENG_IDLE;
            bit_cnt    <= '0;
            rx_sh      <= '0;
            rx_hold    <= '0;
            tx_buf     <= '0;
            tx_sh      <= '0;
            armed      <= 1'b0;
            ctl_ack    <= 1'b0;
            drive_next <= 1'b0;
            hold_pend  <= 1'b0;
            hold_cnt   <= '0;
            oe_q       <= 1'b0;
            rxv_q      <= 1'b0;
        end else begin
            rxv_q <= 1'b0;
            if (tx_load) begin
                tx_buf <= tx_byte;
                armed  <= 1'b1;
            end
            if (ev.start) begin
                state     <= ENG_RX;
                bit_cnt   <= '0;
                oe_q      <= 1'b0;
                hold_pend <= 1'b0;
                armed     <= tx_load;
            end else if (ev.stop) begin
                state     <= ENG_IDLE;
                bit_cnt   <= '0;
                oe_q      <= 1'b0;
                hold_pend <= 1'b0;
                armed     <= 1'b0;
            end else begin
                if (hold_pend) begin
                    if (hold_cnt == HW'(HOLD_CLKS - 1)) begin
                        oe_q      <= drive_next;
                        hold_pend <= 1'b0;
                    end else begin
                        hold_cnt <= hold_cnt + 1'b1;
                    end
                end
                unique case (state)
                    ENG_IDLE: begin
                    end
                    ENG_RX: begin
                        if (ev.rise) begin
                            rx_sh   <= {rx_sh[6:0], sda_f};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (ev.fall && bit_cnt == BW'(BYTE_BITS)) begin
                            rx_hold    <= rx_sh;
                            rxv_q      <= 1'b1;
                            state      <= ENG_RX_ACK;
                            drive_next <= 1'b1;
                            hold_pend  <= 1'b1;
                            hold_cnt   <= '0;
                        end
                    end
                    ENG_RX_ACK: begin
                        if (ev.fall) begin
                            bit_cnt   <= '0;
                            hold_pend <= 1'b1;
                            hold_cnt  <= '0;
                            if (armed) begin
                                state      <= ENG_TX;
                                drive_next <= ~tx_buf[7];
                                tx_sh      <= {tx_buf[6:0], 1'b1};
                                armed      <= 1'b0;
                            end else begin
                                state      <= ENG_RX;
                                drive_next <= 1'b0;
                            end
                        end
                    end
                    ENG_TX: begin
                        if (ev.rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (ev.fall) begin
                            hold_pend <= 1'b1;
                            hold_cnt  <= '0;
                            if (bit_cnt == BW'(BYTE_BITS)) begin
                                state      <= ENG_TX_ACK;
                                drive_next <= 1'b0;
                            end else begin
                                drive_next <= ~tx_sh[7];
                                tx_sh      <= {tx_sh[6:0], 1'b1};
                            end
                        end
                    end
                    ENG_TX_ACK: begin
                        if (ev.rise) begin
                            ctl_ack <= ~sda_f;
                        end else if (ev.fall) begin
                            bit_cnt <= '0;
                            if (ctl_ack && armed) begin
                                state      <= ENG_TX;
                                drive_next <= ~tx_buf[7];
                                tx_sh      <= {tx_buf[6:0], 1'b1};
                                armed      <= 1'b0;
                                hold_pend  <= 1'b1;
                                hold_cnt   <= '0;
                            end else begin
                                state <= ENG_IDLE;
                            end
                        end
                    end
                    default: state <= ENG_IDLE;
                endcase
            end
        end
    end

    assign sda_oe   = oe_q;
    assign rx_valid = rxv_q;
    assign rx_byte  = rx_hold;

endmodule

// File: rtl/twi_standby_ctl.sv
module twi_standby_ctl (
    input  logic              clk,
    input  logic              rst,
    input  twi_pkg::bus_evt_t ev,
    input  logic              busy_i,
    output logic              standby
);
    logic in_txn;
    logic txn_next;

    always_comb begin
        txn_next = in_txn;
        if (ev.start) begin
            txn_next = 1'b1;
        end else if (ev.stop) begin
            txn_next = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_txn  <= 1'b0;
            standby <= 1'b1;
        end else begin
            in_txn  <= txn_next;
            standby <= ~txn_next & ~busy_i;
        end
    end

endmodule

// File: rtl/twi_phy.sv
module twi_phy #(
    parameter int FILT_LEN  = 4,
    parameter int HOLD_CLKS = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       busy_i,
    input  logic       tx_load,
    input  logic [7:0] tx_byte,
    output logic       scl_filt,
    output logic       sda_filt,
    output logic       sda_oe,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       standby
);
    import twi_pkg::*;

    localparam int LINES = 2;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] filt_lines;
    bus_evt_t         ev;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_filt
        twi_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_lines[g]),
            .filt (filt_lines[g])
        );
    end

    assign scl_filt = filt_lines[0];
    assign sda_filt = filt_lines[1];

    twi_bus_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_f (filt_lines[0]),
        .sda_f (filt_lines[1]),
        .ev    (ev)
    );

    twi_bit_engine #(.HOLD_CLKS(HOLD_CLKS)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .sda_f    (filt_lines[1]),
        .tx_load  (tx_load),
        .tx_byte  (tx_byte),
        .sda_oe   (sda_oe),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte)
    );

    twi_standby_ctl u_standby (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .busy_i  (busy_i),
        .standby (standby)
    );

endmodule

// File: rtl/twi_phy_chk.sv
module twi_phy_chk (
    input logic clk,
    input logic rst,
    input logic scl_filt,
    input logic sda_oe,
    input logic rx_valid,
    input logic busy_i,
    input logic standby
);
    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R4

    AST_RX_LINE_FREE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !sda_oe); // R4

    AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_filt); // R6

    AST_STBY_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> standby); // R9

    AST_BUSY_NO_STBY: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> !standby); // R10

    AST_STBY_RISE_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(standby) |-> !$past(busy_i)); // R10

endmodule

bind twi_phy twi_phy_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_filt (scl_filt),
    .sda_oe   (sda_oe),
    .rx_valid (rx_valid),
    .busy_i   (busy_i),
    .standby  (standby)
);

// File: tb/twi_phy_tb.sv
module twi_phy_tb;
    localparam int FILT = 4;
    localparam int HOLD = 3;
    localparam int HP   = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_c = 1'b1;
    logic       sda_c = 1'b1;
    logic       busy_i = 1'b0;
    logic       tx_load = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       scl_filt, sda_filt, sda_oe, rx_valid, standby;
    logic [7:0] rx_byte;
    logic       sda_line;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    assign sda_line = sda_c & ~sda_oe;

    twi_phy #(.FILT_LEN(FILT), .HOLD_CLKS(HOLD)) u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_c), .sda_i(sda_line),
        .busy_i(busy_i), .tx_load(tx_load), .tx_byte(tx_byte),
        .scl_filt(scl_filt), .sda_filt(sda_filt), .sda_oe(sda_oe),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .standby(standby)
    );

    // monitors
    int         rx_cnt = 0;
    logic [7:0] rx_last = '0;
    logic       clr = 1'b0;
    bit         sda_low_seen = 0, scl_low_seen = 0, oe_seen = 0;
    logic       prev_scl = 1'b1, prev_oe = 1'b0;
    int         since_fall = 1000;
    int         hold_bad = 0;

    always @(posedge clk) begin
        if (rx_valid) begin
            rx_cnt  <= rx_cnt + 1;
            rx_last <= rx_byte;
        end
        if (clr) begin
            sda_low_seen <= 0; scl_low_seen <= 0; oe_seen <= 0;
        end else begin
            if (!sda_filt) sda_low_seen <= 1;
            if (!scl_filt) scl_low_seen <= 1;
            if (sda_oe) oe_seen <= 1;
        end
        prev_scl <= scl_filt;
        prev_oe  <= sda_oe;
        if (prev_scl && !scl_filt) since_fall <= 0;
        else if (since_fall < 1000) since_fall <= since_fall + 1;
        if (!rst && sda_oe != prev_oe && (scl_filt || since_fall < HOLD))
            hold_bad <= hold_bad + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_flags();
        clr = 1'b1; tick(1); clr = 1'b0;
    endtask

    task automatic bus_bit(input bit b, output bit seen);
        sda_c = b; tick(HP);
        scl_c = 1'b1; tick(HP);
        seen = sda_line; tick(HP);
        scl_c = 1'b0; tick(HP);
    endtask

    task automatic bus_start();
        sda_c = 1'b1; tick(HP);
        scl_c = 1'b1; tick(HP);
        sda_c = 1'b0; tick(HP);
        scl_c = 1'b0; tick(HP);
    endtask

    task automatic bus_stop();
        sda_c = 1'b0; tick(HP);
        scl_c = 1'b1; tick(HP);
        sda_c = 1'b1; tick(2 * HP);
    endtask

    task automatic write_byte(input logic [7:0] v, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) bus_bit(v[i], s);
        bus_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] v);
        bit s;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            bus_bit(1'b1, s);
            v = {v[6:0], s};
        end
        bus_bit(!give_ack, s);
    endtask

    task automatic arm(input logic [7:0] v);
        tx_byte = v; tx_load = 1'b1; tick(1); tx_load = 1'b0;
    endtask

    initial begin
        bit         ack, s;
        logic [7:0] rd;
        int         base;

        tick(5);
        rst = 1'b0;
        tick(2);
        // reset state
        check(scl_filt === 1'b1 && sda_filt === 1'b1, "R1", "filtered lines after reset",
              {scl_filt, sda_filt}, 2'b11);
        check(sda_oe === 1'b0, "R5", "sda_oe after reset", sda_oe, 0);
        check(standby === 1'b1, "R9", "standby after reset", standby, 1);
        check(rx_valid === 1'b0, "R4", "rx_valid after reset", rx_valid, 0);
        tick(20);

        // filter sweep on both lines
        for (int w = 1; w <= FILT + 2; w++) begin
            clear_flags();
            scl_c = 1'b0; tick(w); scl_c = 1'b1; tick(20);
            check(scl_low_seen == (w >= FILT), "R1", $sformatf("scl pulse width %0d", w),
                  scl_low_seen, (w >= FILT));
            clear_flags();
            sda_c = 1'b0; tick(w); sda_c = 1'b1; tick(20);
            check(sda_low_seen == (w >= FILT), "R1", $sformatf("sda pulse width %0d", w),
                  sda_low_seen, (w >= FILT));
        end
        check(rx_cnt == 0, "R3", "no bytes from glitches", rx_cnt, 0);
        check(standby === 1'b1, "R9", "standby after start/stop glitch pair", standby, 1);

        // write sweep
        bus_start();
        check(standby === 1'b0, "R9", "standby low after START", standby, 0);
        for (int k = 0; k < 12; k++) begin
            logic [7:0] v;
            v = (k < 8) ? 8'(1 << k) : (k == 8) ? 8'h00 : (k == 9) ? 8'hFF :
                (k == 10) ? 8'hA5 : 8'h5A;
            base = rx_cnt;
            write_byte(v, ack);
            check(ack, "R5", $sformatf("ack of byte %0h", v), ack, 1);
            check(rx_last == v && rx_cnt == base + 1, "R4", "received byte",
                  rx_last, v);
        end
        bus_stop();
        check(standby === 1'b1, "R9", "standby after STOP", standby, 1);

        // repeated START in mid-byte
        bus_start();
        for (int i = 0; i < 4; i++) bus_bit(i[0], s);
        base = rx_cnt;
        bus_start();
        write_byte(8'h69, ack);
        check(rx_last == 8'h69 && rx_cnt == base + 1, "R2", "byte after repeated START",
              rx_last, 8'h69);
        check(ack, "R2", "ack after repeated START", ack, 1);
        bus_stop();

        // STOP in mid-byte, then clocks without START
        bus_start();
        for (int i = 0; i < 3; i++) bus_bit(1'b1, s);
        bus_stop();
        scl_c = 1'b0; tick(HP);
        clear_flags();
        base = rx_cnt;
        write_byte(8'h33, ack);
        check(rx_cnt == base, "R3", "no byte without START", rx_cnt, base);
        check(!oe_seen && !ack, "R3", "no drive without START", oe_seen, 0);
        bus_stop();

        // read sequence
        bus_start();
        arm(8'hC3);
        write_byte(8'hA1, ack);
        check(ack && rx_last == 8'hA1, "R7", "address byte before read", rx_last, 8'hA1);
        arm(8'h3C);
        read_byte(1'b1, rd);
        check(rd == 8'hC3, "R7", "first read byte", rd, 8'hC3);
        read_byte(1'b0, rd);
        check(rd == 8'h3C, "R8", "second read byte after ACK", rd, 8'h3C);
        arm(8'h00);
        clear_flags();
        for (int i = 0; i < 9; i++) bus_bit(1'b1, s);
        check(!oe_seen, "R8", "no drive after NACK", oe_seen, 0);
        bus_stop();
        check(hold_bad == 0, "R6", "drive changes inside hold or SCL high", hold_bad, 0);

        // busy and standby
        busy_i = 1'b1; tick(4);
        check(standby === 1'b0, "R10", "standby while busy idle", standby, 0);
        busy_i = 1'b0; tick(4);
        check(standby === 1'b1, "R10", "standby after busy idle", standby, 1);
        bus_start();
        write_byte(8'h11, ack);
        busy_i = 1'b1;
        bus_stop();
        check(standby === 1'b0, "R10", "standby held off by busy after STOP", standby, 0);
        busy_i = 1'b0; tick(4);
        check(standby === 1'b1, "R10", "standby once busy clears", standby, 1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule